// File: doc/BRIEF.md
# Eight-Line Interrupting GPIO Port on an APB Slave

This block is a general-purpose I/O port of eight lines. It sits as a zero-wait-state slave on an APB-style bus. Each line can be an input or an output. Reads and writes of the data port take their per-line select mask from the address bits, so software can set or sample any subset of lines in one access, with no read-modify-write.

Every line has its own interrupt detector. Three configuration registers set how it senses: level or edge, a both-edges override, and a polarity bit. Edge events are held in sticky status bits that software clears by writing ones. Level status follows the qualified pin level and is not held. An enable register gates the raw status into a masked status, and the OR of the masked bits drives one interrupt output. The pads are modelled as separate input, output and output-enable vectors. The asynchronous inputs pass through a two-flop synchronizer.

A small bus state machine accepts an access only when a setup cycle precedes it.

States:
- `ST_IDLE`: no transfer in progress.
- `ST_SETUP`: the select is high and the enable is low.
- `ST_ACCESS`: a transfer was committed on the previous edge.

Transitions:
- T_START: `ST_IDLE` to `ST_SETUP`.
- T_COMMIT: `ST_SETUP` to `ST_ACCESS`.
- T_ABANDON: `ST_SETUP` to `ST_IDLE`, when the select drops.
- T_HOLD: `ST_SETUP` to `ST_SETUP`.
- T_BACK2BACK: `ST_ACCESS` to `ST_SETUP`.
- T_DONE: `ST_ACCESS` to `ST_IDLE`.

An access phase seen in any state other than `ST_SETUP` is ignored.

Top module: `apbgpio_port`

## Requirements
- R1: After reset, all registers read 0. `pin_oe`, `pin_out` and `irq_out` are 0, so every line is an input, edge sensing is falling-edge and all interrupts are disabled.
- R2: `pready` is always 1 and `pslverr` is always 0. A transfer takes effect only in an access cycle (`psel`=1, `penable`=1) that directly follows a setup cycle (`psel`=1, `penable`=0). An access phase without a setup cycle before it changes nothing and reads 0. `prdata` is 0 outside an accepted read.
- R3: The direction register at offset 0x400 sets one bit per line, where 1 means output. `pin_oe` equals this register.
- R4: A data write anywhere in 0x000–0x3FC uses `paddr[9:2]` as a line mask. Only lines whose mask bit is 1 and that are outputs take the `pwdata` bit. A value written to an input line is not stored, so it does not appear on `pin_out` when that line later becomes an output.
- R5: A data read in 0x000–0x3FC returns, for line i, `paddr[2+i]` AND (the driven output bit if line i is an output, else the synchronized pin input).
- R6: With the sense bit (0x404) at 1, a line uses level detection. The polarity bit (0x40C) selects high (1) or low (0). Raw status (0x414) follows the level, is not latched, and cannot be cleared by the clear register.
- R7: With the sense bit at 0 and the both-edges bit (0x408) at 0, polarity 1 latches rising edges and polarity 0 latches falling edges into raw status.
- R8: With the sense bit at 0 and the both-edges bit at 1, both edges latch and the polarity bit is ignored.
- R9: Writing 1s to the clear register (0x41C) clears the matching latched edge bits and leaves the other bits as they were. A new edge event in the same cycle as a clear of that bit leaves the bit set.
- R10: Masked status (0x418) equals raw status AND the enable register (0x410). `irq_out` is the OR of the masked status bits.
- R11: Writes to raw status, masked status and unmapped offsets (for example 0x420 and 0x800) have no effect. Reads of the clear register and of unmapped offsets return 0.
- R12: The sense, both-edges, polarity, enable and direction registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, 0 outside an accepted read |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| pin_in | input | 8 | Asynchronous pad inputs |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables (1 = drive) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench sweeps all 256 address masks for data writes and reads against a mixed direction pattern. A design that ignored the mask or stored writes to input lines would show wrong values on `pin_out` or in read data. Each of the five sensing modes is driven through low-high-low transitions with clears in between. This catches a latched level, an edge polarity that is swapped, or a both-edges mode that still obeys polarity. The bench times a clear to land in the very cycle a new edge latches, so a design where the clear wins would lose that event. It also checks that an access phase with no setup cycle, writes to read-only or unmapped offsets, and reads of the clear register leave the state untouched and return 0.

// File: rtl/apbgpio_pkg.sv
`timescale 1ns/1ps
package apbgpio_pkg;

    // Bus phase tracker states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } bus_state_e;

    // Word index of control/status registers inside the register page
    typedef enum logic [2:0] {
        RG_DIR   = 3'd0,
        RG_SENSE = 3'd1,
        RG_BOTH  = 3'd2,
        RG_POL   = 3'd3,
        RG_IEN   = 3'd4,
        RG_RAW   = 3'd5,
        RG_MIS   = 3'd6,
        RG_CLR   = 3'd7
    } reg_idx_e;

endpackage

// File: rtl/apbgpio_bus_fsm.sv
`timescale 1ns/1ps
module apbgpio_bus_fsm
    import apbgpio_pkg::*;
(
    input  logic clk,
    input  logic rstn,
    input  logic psel,
    input  logic penable,
    output logic acc_ok
);

    bus_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    // Next state and output
    always_comb begin
        state_d = ST_IDLE;
        acc_ok  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (psel && !penable) state_d = ST_SETUP;       // T_START
            end
            ST_SETUP: begin
                if (psel && penable) begin
                    state_d = ST_ACCESS;                        // T_COMMIT
                    acc_ok  = 1'b1;
                end else if (psel) begin
                    state_d = ST_SETUP;                         // T_HOLD
                end
                                                                // else T_ABANDON
            end
            ST_ACCESS: begin
                if (psel && !penable) state_d = ST_SETUP;       // T_BACK2BACK
                                                                // else T_DONE
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/apbgpio_sync.sv
`timescale 1ns/1ps
module apbgpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rstn,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) begin
            meta_q <= '0;
            cur    <= '0;
            prv    <= '0;
        end else begin
            meta_q <= async_in;
            cur    <= meta_q;
            prv    <= cur;
        end
    end

endmodule

// File: rtl/apbgpio_pin_det.sv
`timescale 1ns/1ps
module apbgpio_pin_det (
    input  logic clk,
    input  logic rstn,
    input  logic cur,
    input  logic prv,
    input  logic lvl_mode,
    input  logic any_edge,
    input  logic pol,
    input  logic clr,
    output logic held,
    output logic raw
);

    logic rise, fall, evt;

    assign rise = cur & ~prv;
    assign fall = ~cur & prv;

    always_comb begin
        if (lvl_mode)      evt = 1'b0;
        else if (any_edge) evt = rise | fall;
        else if (pol)      evt = rise;
        else               evt = fall;
    end

    // Sticky edge latch: a new event beats a clear in the same cycle
    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn)    held <= 1'b0;
        else if (evt) held <= 1'b1;
        else if (clr) held <= 1'b0;
    end

    assign raw = lvl_mode ? (cur == pol) : held;

endmodule

// File: rtl/apbgpio_port.sv
`timescale 1ns/1ps
module apbgpio_port
    import apbgpio_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int ADDR_W = 12
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [NPIN-1:0]   pwdata,
    output logic [NPIN-1:0]   prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq_out
);

    localparam int PAGE_LSB = NPIN + 2;
    localparam int PAGE_W   = ADDR_W - PAGE_LSB;
    localparam logic [PAGE_W-1:0] REG_PAGE = PAGE_W'(1);

    logic acc_ok, wr_stb, rd_stb;
    logic in_data, in_regs;
    logic [NPIN-1:0] mask;
    reg_idx_e idx;

    logic [NPIN-1:0] dir_q, sense_q, both_q, pol_q, ien_q, out_q;
    logic [NPIN-1:0] s_cur, s_prv, edge_latch, raw_stat, mis_stat, clr_vec;
    logic [NPIN-1:0] rd_val;

    apbgpio_bus_fsm u_fsm (
        .clk     (pclk),
        .rstn    (presetn),
        .psel    (psel),
        .penable (penable),
        .acc_ok  (acc_ok)
    );

    assign wr_stb  = acc_ok & pwrite;
    assign rd_stb  = acc_ok & ~pwrite;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    // Address decode
    assign mask    = paddr[PAGE_LSB-1:2];
    assign in_data = (paddr[ADDR_W-1:PAGE_LSB] == '0);
    assign in_regs = (paddr[ADDR_W-1:PAGE_LSB] == REG_PAGE) &&
                     (paddr[PAGE_LSB-1:5] == '0) && (paddr[1:0] == 2'b00);
    assign idx     = reg_idx_e'(paddr[4:2]);

    // Configuration and output registers
    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            ien_q   <= '0;
            out_q   <= '0;
        end else if (wr_stb) begin
            if (in_data) begin
                out_q <= (out_q & ~(mask & dir_q)) | (pwdata & mask & dir_q);
            end else if (in_regs) begin
                unique case (idx)
                    RG_DIR:   dir_q   <= pwdata;
                    RG_SENSE: sense_q <= pwdata;
                    RG_BOTH:  both_q  <= pwdata;
                    RG_POL:   pol_q   <= pwdata;
                    RG_IEN:   ien_q   <= pwdata;
                    RG_RAW, RG_MIS, RG_CLR: ;
                    default: ;
                endcase
            end
        end
    end

    assign clr_vec = (wr_stb && in_regs && idx == RG_CLR) ? pwdata : '0;

    apbgpio_sync #(.W(NPIN)) u_sync (
        .clk      (pclk),
        .rstn     (presetn),
        .async_in (pin_in),
        .cur      (s_cur),
        .prv      (s_prv)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        apbgpio_pin_det u_det (
            .clk      (pclk),
            .rstn     (presetn),
            .cur      (s_cur[i]),
            .prv      (s_prv[i]),
            .lvl_mode (sense_q[i]),
            .any_edge (both_q[i]),
            .pol      (pol_q[i]),
            .clr      (clr_vec[i]),
            .held     (edge_latch[i]),
            .raw      (raw_stat[i])
        );
    end

    assign mis_stat = raw_stat & ien_q;
    assign irq_out  = |mis_stat;
    assign pin_out  = out_q;
    assign pin_oe   = dir_q;

    // Read mux
    always_comb begin
        rd_val = '0;
        if (in_data) begin
            rd_val = mask & ((dir_q & out_q) | (~dir_q & s_cur));
        end else if (in_regs) begin
            unique case (idx)
                RG_DIR:   rd_val = dir_q;
                RG_SENSE: rd_val = sense_q;
                RG_BOTH:  rd_val = both_q;
                RG_POL:   rd_val = pol_q;
                RG_IEN:   rd_val = ien_q;
                RG_RAW:   rd_val = raw_stat;
                RG_MIS:   rd_val = mis_stat;
                RG_CLR:   rd_val = '0;
                default:  rd_val = '0;
            endcase
        end
    end

    assign prdata = rd_stb ? rd_val : '0;

endmodule

// File: rtl/apbgpio_chk.sv
`timescale 1ns/1ps
module apbgpio_chk #(
    parameter int NPIN   = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rstn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] paddr,
    input logic [NPIN-1:0]   pwdata,
    input logic [NPIN-1:0]   prdata,
    input logic [NPIN-1:0]   pin_out,
    input logic [NPIN-1:0]   pin_oe,
    input logic [NPIN-1:0]   ien_q,
    input logic [NPIN-1:0]   edge_latch,
    input logic [NPIN-1:0]   clr_vec,
    input logic              irq_out
);

    localparam logic [ADDR_W-1:0] DIR_OFF = ADDR_W'(1) << (NPIN + 2);
    localparam logic [ADDR_W-1:0] CLR_OFF = DIR_OFF + ADDR_W'(28);

    AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rstn)
        (wr_stb && paddr == DIR_OFF) |=> (pin_oe == $past(pwdata))); // R3

    AST_INPUT_LINE_HELD: assert property (@(posedge clk) disable iff (!rstn)
        ((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0); // R4

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rstn)
        ($past(edge_latch) & ~$past(clr_vec) & ~edge_latch) == '0); // R9

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstn)
        irq_out |-> (ien_q != '0)); // R10

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstn)
        !(psel && penable) |-> (prdata == '0)); // R2

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstn)
        (psel && penable && !pwrite && paddr == CLR_OFF) |-> (prdata == '0)); // R11

endmodule

bind apbgpio_port apbgpio_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
    .clk        (pclk),
    .rstn       (presetn),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .wr_stb     (wr_stb),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .prdata     (prdata),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .ien_q      (ien_q),
    .edge_latch (edge_latch),
    .clr_vec    (clr_vec),
    .irq_out    (irq_out)
);

// File: tb/tb_apbgpio_port.sv
`timescale 1ns/1ps
module tb_apbgpio_port;

    localparam logic [11:0] A_DIR = 12'h400, A_SENSE = 12'h404, A_BOTH = 12'h408,
                            A_POL = 12'h40C, A_IEN = 12'h410, A_RAW = 12'h414,
                            A_MIS = 12'h418, A_CLR = 12'h41C;

    logic clk = 1'b0;
    logic rstn = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [7:0] pwdata = '0, pin_in = '0;
    logic [7:0] prdata, pin_out, pin_oe;
    logic pready, pslverr, irq_out;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    apbgpio_port dut (
        .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, exp_out, dir, exp;
        repeat (3) @(negedge clk);
        rstn = 1'b1;
        @(negedge clk);

        // R1 / R2 reset state
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 irq_out", {7'd0, irq_out}, 8'h00);
        chk("R2 pready", {7'd0, pready}, 8'h01);
        chk("R2 pslverr", {7'd0, pslverr}, 8'h00);
        for (int k = 0; k < 8; k++) begin
            rd(A_DIR + 12'(4 * k), v);
            chk("R1 reg reset", v, 8'h00);
        end

        // R2 access phase without setup is ignored
        @(negedge clk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = A_DIR; pwdata = 8'hFF;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        @(negedge clk);
        chk("R2 no-setup write", pin_oe, 8'h00);
        @(negedge clk);
        psel = 1'b1; penable = 1'b1; paddr = A_DIR;
        #1 chk("R2 no-setup read", prdata, 8'h00);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        chk("R2 idle prdata", prdata, 8'h00);

        // R12 / R3 readback
        wr(A_SENSE, 8'hA1); rd(A_SENSE, v); chk("R12 sense", v, 8'hA1);
        wr(A_BOTH, 8'h3C);  rd(A_BOTH, v);  chk("R12 both", v, 8'h3C);
        wr(A_POL, 8'h5E);   rd(A_POL, v);   chk("R12 pol", v, 8'h5E);
        wr(A_IEN, 8'h81);   rd(A_IEN, v);   chk("R12 ien", v, 8'h81);
        wr(A_DIR, 8'h3C);   rd(A_DIR, v);   chk("R12 dir", v, 8'h3C);
        chk("R3 pin_oe", pin_oe, 8'h3C);
        wr(A_SENSE, 8'h00); wr(A_BOTH, 8'h00); wr(A_POL, 8'h00); wr(A_IEN, 8'h00);

        // R4 masked data write sweep
        dir = 8'hF0; wr(A_DIR, dir); chk("R3 pin_oe F0", pin_oe, dir);
        exp_out = 8'h00;
        for (int m = 0; m < 256; m++) begin
            logic [7:0] d, mk;
            mk = 8'(m);
            d  = 8'(m * 37 + 11);
            wr({2'b00, mk, 2'b00}, d);
            exp_out = (exp_out & ~(mk & dir)) | (d & mk & dir);
            chk("R4 masked write", pin_out, exp_out);
        end
        wr(A_DIR, 8'hFF);
        chk("R4 input write not stored", pin_out, exp_out & 8'hF0);

        // R5 masked read sweep
        dir = 8'h0F; wr(A_DIR, dir);
        pin_in = 8'h96; settle();
        for (int m = 0; m < 256; m++) begin
            logic [7:0] mk;
            mk = 8'(m);
            rd({2'b00, mk, 2'b00}, v);
            chk("R5 masked read", v, mk & ((dir & exp_out & 8'hF0) | (~dir & 8'h96)));
        end
        wr(A_DIR, 8'h00);

        // R6 / R7 / R8 sensing modes
        for (int md = 0; md < 5; md++) begin
            logic [7:0] e_hi, e_cl, e_lo;
            string tg;
            unique case (md)
                0: begin wr(A_SENSE, 8'hFF); wr(A_BOTH, 8'h00); wr(A_POL, 8'hFF);
                         tg = "R6 level-high"; e_hi = 8'hFF; e_cl = 8'hFF; e_lo = 8'h00; end
                1: begin wr(A_SENSE, 8'hFF); wr(A_BOTH, 8'h00); wr(A_POL, 8'h00);
                         tg = "R6 level-low";  e_hi = 8'h00; e_cl = 8'h00; e_lo = 8'hFF; end
                2: begin wr(A_SENSE, 8'h00); wr(A_BOTH, 8'h00); wr(A_POL, 8'hFF);
                         tg = "R7 rising";     e_hi = 8'hFF; e_cl = 8'h00; e_lo = 8'h00; end
                3: begin wr(A_SENSE, 8'h00); wr(A_BOTH, 8'h00); wr(A_POL, 8'h00);
                         tg = "R7 falling";    e_hi = 8'h00; e_cl = 8'h00; e_lo = 8'hFF; end
                default: begin wr(A_SENSE, 8'h00); wr(A_BOTH, 8'hFF); wr(A_POL, 8'h5A);
                         tg = "R8 both-edges"; e_hi = 8'hFF; e_cl = 8'h00; e_lo = 8'hFF; end
            endcase
            pin_in = 8'h00; settle();
            wr(A_CLR, 8'hFF); rd(A_RAW, v);
            chk({tg, " start"}, v, (md == 1) ? 8'hFF : 8'h00);
            pin_in = 8'hFF; settle(); rd(A_RAW, v); chk({tg, " high"}, v, e_hi);
            wr(A_CLR, 8'hFF); rd(A_RAW, v); chk({tg, " after clear"}, v, e_cl);
            pin_in = 8'h00; settle(); rd(A_RAW, v); chk({tg, " low"}, v, e_lo);
        end

        // R10 / R9 masking and partial clear
        wr(A_SENSE, 8'h00); wr(A_BOTH, 8'h00); wr(A_POL, 8'hFF);
        wr(A_CLR, 8'hFF);
        wr(A_IEN, 8'h0F);
        pin_in = 8'h3C; settle();
        rd(A_RAW, v); chk("R10 raw", v, 8'h3C);
        rd(A_MIS, v); chk("R10 masked", v, 8'h0C);
        chk("R10 irq on", {7'd0, irq_out}, 8'h01);
        wr(A_IEN, 8'hC0);
        rd(A_MIS, v); chk("R10 masked off", v, 8'h00);
        chk("R10 irq off", {7'd0, irq_out}, 8'h00);
        wr(A_CLR, 8'h30);
        rd(A_RAW, v); chk("R9 partial clear", v, 8'h0C);
        wr(A_IEN, 8'hFF);
        chk("R10 irq re-enabled", {7'd0, irq_out}, 8'h01);
        wr(A_CLR, 8'h0C);
        chk("R9 irq after full clear", {7'd0, irq_out}, 8'h00);

        // R9 event and clear in the same cycle
        pin_in = 8'h00; settle(); wr(A_CLR, 8'hFF);
        rd(A_RAW, v); chk("R9 pre-race clean", v, 8'h00);
        @(negedge clk);
        pin_in = 8'h01;
        wr(A_CLR, 8'h01);
        rd(A_RAW, v); chk("R9 event beats clear", v, 8'h01);

        // R11 read-only and unmapped offsets
        wr(A_RAW, 8'h00); rd(A_RAW, v); chk("R11 raw write ignored", v, 8'h01);
        wr(A_MIS, 8'h00); rd(A_MIS, v); chk("R11 mis write ignored", v, 8'h01);
        rd(A_CLR, v); chk("R11 clear reads zero", v, 8'h00);
        wr(12'h420, 8'hFF); rd(12'h420, v); chk("R11 unmapped 420", v, 8'h00);
        wr(12'h800, 8'hFF); rd(12'h800, v); chk("R11 unmapped 800", v, 8'h00);
        rd(A_DIR, v); chk("R11 dir untouched", v, 8'h00);
        rd(A_IEN, v); chk("R11 ien untouched", v, 8'hFF);
        exp = 8'h00;
        chk("R11 pin_oe untouched", pin_oe, exp);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule